// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent 32-bit timer channels behind a small synchronous register bus. Each channel owns a down-counter, a reload value, a control word and a private prescaler. The prescaler divides the common module clock into a count clock. A shared run register turns each channel on or off on its own. When a running counter is at zero and takes a count-clock tick, it reloads from its reload value and raises a sticky underflow flag. If the flag is set and the channel's interrupt enable is on, that channel's interrupt line goes high.

The block is typically used as a periodic tick source, with a nonzero reload value, or as a single-event delay, with a reload value of zero. Software loads the counter while the channel is halted, sets the run bit, and services the interrupt by writing the flag bit to zero. The asynchronous active-low reset is released into the block through a two-stage synchroniser.

Top module: `dct_timer_unit`

## Requirements
- R1: After reset every control word reads 0x0020 (divide select 0, interrupt enable on, flag clear). Every counter and reload value reads 0, the run register reads 0 and all interrupt lines are low.
- R2: The run register is at address 0x00. Channel n's registers start at 0x04 + 12·n: the reload value at offset 0, the counter at offset 4 and the control word at offset 8. The control word reads zero-extended to 32 bits, and unmapped addresses read 0.
- R3: Write size code 0 (byte) updates only bits [7:0] of the target, code 1 (word) only bits [15:0], and codes 2 and 3 (long) all 32 bits.
- R4: Bit n of the run register runs channel n when 1. While that bit is 0, the channel's counter holds its value unless it is written, and its prescaler is held cleared.
- R5: Control bits [2:0] select the count clock: the module clock divided by 4, 16, 64 or 256 for select values 0 to 3, and divided by 4 for values 4 to 7. The first tick comes exactly one division period after the run bit rises.
- R6: On each tick a nonzero counter decrements by one. A zero counter underflows instead and loads the reload value.
- R7: Control bit 8 is the underflow flag. Hardware sets it on underflow. A word or long write with bit 8 at 0 clears it. Writing 1 to bit 8, or a byte write, leaves it unchanged. An underflow in the same cycle as a clearing write leaves it set.
- R8: Channel n's interrupt line is high exactly when its flag and its interrupt enable (control bit 5) are both 1.
- R9: An underflow that loads a reload value of 0 leaves the channel holding at zero. It produces no further underflows until its counter or reload value is written.
- R10: A bus write to a counter takes precedence over a tick that occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_size | input | 2 | Write size: 0 byte, 1 word, 2 or 3 long |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bench first aims a word-sized flag clear at the exact cycle of an underflow. A design that lets the clear win would lose an interrupt. It then lets a zero reload value run for many ticks after the first underflow. A design that ignores the one-shot hold would raise the flag again on every tick. It checks the first tick against the run-bit rise for divide-by-4 and divide-by-16 and for a reserved select value. An off-by-one prescaler, or one that is not restarted, moves the decrement to the wrong cycle. Finally it writes a counter in the cycle a tick is due. A design that lets the tick win would show the decremented value instead of the written one.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned PRE_W    = 8;
  localparam int unsigned RUN_W    = 8;
  localparam int unsigned FLAG_BIT = 8;
  localparam int unsigned IE_BIT   = 5;

  localparam int unsigned START_ADDR = 0;
  localparam int unsigned CH_BASE    = 4;
  localparam int unsigned CH_STRIDE  = 12;
  localparam int unsigned OFF_RELOAD = 0;
  localparam int unsigned OFF_COUNT  = 4;
  localparam int unsigned OFF_CTRL   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  // Replace only the lanes covered by the transfer size.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input xfer_size_e        sz
  );
    logic [DATA_W-1:0] res;
    case (sz)
      SZ_BYTE: res = {old_v[DATA_W-1:8],  new_v[7:0]};
      SZ_WORD: res = {old_v[DATA_W-1:16], new_v[15:0]};
      default: res = new_v;
    endcase
    return res;
  endfunction

  // Terminal prescaler count: (4 << 2*sel) - 1, reserved selects fall back to 3.
  function automatic logic [PRE_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] full;
    logic [PRE_W:0] lim;
    if (sel[2]) full = (PRE_W+1)'(4);
    else        full = (PRE_W+1)'(4) << {sel[1:0], 1'b0};
    lim = full - (PRE_W+1)'(1);
    return lim[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q, pre_d, lim;

  always_comb begin
    lim  = div_limit(sel);
    tick = run && (pre_q >= lim);
    if (!run || tick) pre_d = '0;
    else              pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R5: ticks are at least four module clocks apart
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R4: a halted channel never ticks and restarts its division from zero
  p_halt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              reload_we,
  input  logic              count_we,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  input  xfer_size_e        wsize,
  output logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] count_q,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic              irq
);
  logic              tick, underflow, flag_clr;
  logic [DATA_W-1:0] reload_d, count_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              ie_q, ie_d, flag_q, flag_d, hold_q, hold_d;

  dct_prescaler u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel_q),
    .tick (tick)
  );

  always_comb begin
    underflow = tick && (count_q == '0) && !hold_q;
    flag_clr  = ctrl_we && (wsize != SZ_BYTE) && !wdata[FLAG_BIT];

    reload_d = reload_q;
    if (reload_we) reload_d = lane_merge(reload_q, wdata, wsize);

    count_d = count_q;
    if (count_we)                       count_d = lane_merge(count_q, wdata, wsize);
    else if (underflow)                 count_d = reload_q;
    else if (tick && count_q != '0)     count_d = count_q - DATA_W'(1);

    hold_d = hold_q;
    if (count_we || reload_we)              hold_d = 1'b0;
    else if (underflow && reload_q == '0)   hold_d = 1'b1;

    sel_d = sel_q;
    ie_d  = ie_q;
    if (ctrl_we) begin
      sel_d = wdata[SEL_W-1:0];
      ie_d  = wdata[IE_BIT];
    end

    flag_d = flag_q;
    if (underflow)     flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;

    ctrl_rd = '0;
    ctrl_rd[SEL_W-1:0] = sel_q;
    ctrl_rd[IE_BIT]    = ie_q;
    ctrl_rd[FLAG_BIT]  = flag_q;
    irq = flag_q && ie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      sel_q    <= '0;
      ie_q     <= 1'b1;
      flag_q   <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      count_q  <= count_d;
      sel_q    <= sel_d;
      ie_q     <= ie_d;
      flag_q   <= flag_d;
      hold_q   <= hold_d;
    end
  end

  // R6: a plain tick decrements by one
  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q != '0 && !count_we) |=> (count_q == $past(count_q) - DATA_W'(1)));
  // R6: underflow loads the reload value
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !count_we) |=> (count_q == $past(reload_q)));
  // R7: underflow always leaves the flag set, even against a clear
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> flag_q);
  // R8: a raised interrupt stays high until the control word is written
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_we) |=> irq);
  // R4: a halted counter holds unless written
  p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !count_we) |=> $stable(count_q));
  // R9: a spent one-shot channel keeps its counter at rest
  p_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !count_we && !reload_we) |=> ($stable(count_q) && $stable(hold_q)));
  // R10: a counter write lands even when a tick coincides
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_we && wsize != SZ_BYTE && wsize != SZ_WORD) |=> (count_q == $past(wdata)));
endmodule

// File: rtl/dct_regbus.sv
module dct_regbus
  import dct_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic [NCH-1:0]               run_q,
  input  logic [NCH-1:0][DATA_W-1:0]   reload_v,
  input  logic [NCH-1:0][DATA_W-1:0]   count_v,
  input  logic [NCH-1:0][CTRL_W-1:0]   ctrl_v,
  output logic                         start_we,
  output logic [NCH-1:0]               reload_we,
  output logic [NCH-1:0]               count_we,
  output logic [NCH-1:0]               ctrl_we,
  output logic [DATA_W-1:0]            rdata
);
  assign start_we = bus_wr && (bus_addr == ADDR_W'(START_ADDR));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    localparam int unsigned BASE = CH_BASE + CH_STRIDE * n;
    assign reload_we[n] = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_RELOAD));
    assign count_we[n]  = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_COUNT));
    assign ctrl_we[n]   = bus_wr && (bus_addr == ADDR_W'(BASE + OFF_CTRL));
  end

  always_comb begin
    rdata = '0;
    if (bus_addr == ADDR_W'(START_ADDR)) rdata = DATA_W'(run_q);
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_RELOAD)) rdata = reload_v[n];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_COUNT))  rdata = count_v[n];
      if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFF_CTRL))   rdata = DATA_W'(ctrl_v[n]);
    end
  end

  // R2: one address selects at most one register
  p_single_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_we, reload_we, count_we, ctrl_we}));
endmodule

// File: rtl/dct_timer_unit.sv
module dct_timer_unit
  import dct_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic [1:0]                 rs_q;
  logic                       rst_sync_n;
  logic [NCH-1:0]             run_q, run_d;
  logic                       start_we;
  logic [NCH-1:0]             reload_we, count_we, ctrl_we;
  logic [NCH-1:0][DATA_W-1:0] reload_v, count_v;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
  xfer_size_e                 wsize;

  assign wsize = xfer_size_e'(bus_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    run_d = run_q;
    if (start_we) run_d = bus_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= '0;
    else             run_q <= run_d;
  end

  dct_regbus #(.NCH(NCH), .ADDR_W(ADDR_W)) u_bus (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .run_q    (run_q),
    .reload_v (reload_v),
    .count_v  (count_v),
    .ctrl_v   (ctrl_v),
    .start_we (start_we),
    .reload_we(reload_we),
    .count_we (count_we),
    .ctrl_we  (ctrl_we),
    .rdata    (bus_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dct_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .run      (run_q[n]),
      .reload_we(reload_we[n]),
      .count_we (count_we[n]),
      .ctrl_we  (ctrl_we[n]),
      .wdata    (bus_wdata),
      .wsize    (wsize),
      .reload_q (reload_v[n]),
      .count_q  (count_v[n]),
      .ctrl_rd  (ctrl_v[n]),
      .irq      (irq[n])
    );
  end

  // R4: run bits change only through a run-register write
  p_run_stable_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_we |=> $stable(run_q));
  initial p_nch_fits_r2: assert (NCH >= 1 && NCH <= RUN_W);
endmodule

// File: tb/dct_timer_unit_tb_top.sv
module dct_timer_unit_tb_top;
  localparam int NCH = 3;
  localparam int AW  = 8;

  logic          clk, rst_n, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NCH-1:0] irq;

  dct_timer_unit #(.NCH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0, done = 0;

  // behavioural reference state
  logic [31:0] m_rel [NCH];
  logic [31:0] m_cnt [NCH];
  int          m_sel [NCH];
  int          m_pre [NCH];
  bit          m_ie [NCH], m_flag [NCH], m_spent [NCH];
  logic [NCH-1:0] m_run;

  function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] v, logic [1:0] s);
    if (s == 2'd0) return (o & 32'hFFFF_FF00) | (v & 32'hFF);
    if (s == 2'd1) return (o & 32'hFFFF_0000) | (v & 32'hFFFF);
    return v;
  endfunction

  function automatic int lim_of(int s);
    if (s <= 3) return (4 << (2 * s)) - 1;
    return 3;
  endfunction

  function automatic int base_of(int n);
    return 4 + 12 * n;
  endfunction

  function automatic logic [31:0] mread(logic [AW-1:0] a);
    logic [31:0] r = 0;
    if (a == 0) r = 32'(m_run);
    for (int n = 0; n < NCH; n++) begin
      if (a == AW'(base_of(n)))     r = m_rel[n];
      if (a == AW'(base_of(n) + 4)) r = m_cnt[n];
      if (a == AW'(base_of(n) + 8)) r = (32'(m_flag[n]) << 8) | (32'(m_ie[n]) << 5) | 32'(m_sel[n]);
    end
    return r;
  endfunction

  function automatic bit uf_due(int n);
    return m_run[n] && m_pre[n] >= lim_of(m_sel[n]) && m_cnt[n] == 0 && !m_spent[n];
  endfunction

  function automatic bit tick_due(int n);
    return m_run[n] && m_pre[n] >= lim_of(m_sel[n]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        m_rel[n] = 0; m_cnt[n] = 0; m_sel[n] = 0; m_pre[n] = 0;
        m_ie[n] = 1; m_flag[n] = 0; m_spent[n] = 0;
      end
      m_run = 0;
    end else begin
      for (int n = 0; n < NCH; n++) begin
        bit tk, uf, w_rel, w_cnt, w_ctl;
        logic [31:0] old_rel;
        tk = 0;
        w_rel = bus_wr && bus_addr == AW'(base_of(n));
        w_cnt = bus_wr && bus_addr == AW'(base_of(n) + 4);
        w_ctl = bus_wr && bus_addr == AW'(base_of(n) + 8);
        if (m_run[n]) begin
          if (m_pre[n] >= lim_of(m_sel[n])) begin tk = 1; m_pre[n] = 0; end
          else m_pre[n] = m_pre[n] + 1;
        end else m_pre[n] = 0;
        uf = tk && m_cnt[n] == 0 && !m_spent[n];
        old_rel = m_rel[n];
        if (w_cnt) m_cnt[n] = mrg(m_cnt[n], bus_wdata, bus_size);
        else if (uf) m_cnt[n] = old_rel;
        else if (tk && m_cnt[n] != 0) m_cnt[n] = m_cnt[n] - 1;
        if (w_rel) m_rel[n] = mrg(m_rel[n], bus_wdata, bus_size);
        if (w_cnt || w_rel) m_spent[n] = 0;
        else if (uf && old_rel == 0) m_spent[n] = 1;
        if (uf) m_flag[n] = 1;
        else if (w_ctl && bus_size != 0 && !bus_wdata[8]) m_flag[n] = 0;
        if (w_ctl) begin m_sel[n] = int'(bus_wdata[2:0]); m_ie[n] = bus_wdata[5]; end
      end
      if (bus_wr && bus_addr == 0) m_run = bus_wdata[NCH-1:0];
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [AW-1:0] a);
    if (a == 0) return "R4";
    for (int n = 0; n < NCH; n++) begin
      if (a == AW'(base_of(n)))     return "R3";
      if (a == AW'(base_of(n) + 4)) return "R6";
      if (a == AW'(base_of(n) + 8)) return "R7";
    end
    return "R2";
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      logic [31:0] e;
      e = mread(bus_addr);
      check(bus_rdata == e, tag_of(bus_addr), bus_rdata, e);
      for (int n = 0; n < NCH; n++)
        check(irq[n] == (m_flag[n] && m_ie[n]), "R8 irq", 32'(irq[n]), 32'(m_flag[n] && m_ie[n]));
    end
  end

  task automatic idle(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [31:0] d, logic [1:0] s);
    bus_addr = AW'(a); bus_wdata = d; bus_size = s; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    bus_addr = AW'(a);
    @(negedge clk);
    check(bus_rdata == exp, tag, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic rd_get(int a, output logic [31:0] v);
    bus_addr = AW'(a);
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #1;
  endtask

  function automatic string fin();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    return "";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      void'(fin());
      $finish;
    end
  end

  initial begin
    logic [31:0] v1, v2;
    bus_addr = 0; bus_wr = 0; bus_size = 0; bus_wdata = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(5);
    cmp_en = 1;

    // R1 reset state
    rd_chk(8'h0C, 32'h20, "R1 ctrl0");
    rd_chk(8'h14, 32'h0,  "R1 cnt1");
    rd_chk(8'h1C, 32'h0,  "R1 rel2");
    rd_chk(8'h00, 32'h0,  "R1 run");
    check(irq == 0, "R1 irq", 32'(irq), 0);

    // R2 map
    rd_chk(8'hFC, 32'h0, "R2 unmapped");
    wr(8'h10, 32'h1234_5678, 2'd2);
    rd_chk(8'h10, 32'h1234_5678, "R2 rel1");
    wr(8'h1C, 32'hCAFE_0001, 2'd3);
    rd_chk(8'h1C, 32'hCAFE_0001, "R2 rel2");
    rd_chk(8'h04, 32'h0, "R2 rel0 untouched");

    // R3 sizes
    wr(8'h10, 32'hFFFF_FFAB, 2'd0);
    rd_chk(8'h10, 32'h1234_56AB, "R3 byte");
    wr(8'h10, 32'hFFFF_CDEF, 2'd1);
    rd_chk(8'h10, 32'h1234_CDEF, "R3 word");

    // R5/R6 channel 0 divide-by-4
    wr(8'h04, 5, 2'd2);
    wr(8'h08, 2, 2'd2);
    wr(8'h00, 32'h1, 2'd0);
    idle(3);
    rd_chk(8'h08, 2, "R5 before first tick");
    rd_chk(8'h08, 1, "R5 first tick");
    idle(7);
    rd_chk(8'h08, 5, "R6 reload");
    rd_chk(8'h0C, 32'h120, "R7 flag set");
    check(irq[0] == 1, "R8 irq0 high", 32'(irq[0]), 1);

    // R7 flag clear rules
    wr(8'h0C, 32'h20, 2'd0);
    rd_chk(8'h0C, 32'h120, "R7 byte keeps flag");
    wr(8'h0C, 32'h120, 2'd1);
    rd_chk(8'h0C, 32'h120, "R7 write one keeps flag");
    wr(8'h0C, 32'h20, 2'd1);
    rd_chk(8'h0C, 32'h20, "R7 clear");
    check(irq[0] == 0, "R8 irq0 low", 32'(irq[0]), 0);

    // R8 enable off
    wr(8'h0C, 32'h0, 2'd1);
    idle(30);
    rd_chk(8'h0C, 32'h100, "R8 flag without enable");
    check(irq[0] == 0, "R8 masked", 32'(irq[0]), 0);

    // R7 set beats clear
    while (!uf_due(0)) idle(1);
    wr(8'h0C, 32'h0, 2'd1);
    rd_chk(8'h0C, 32'h100, "R7 set wins");

    // R10 write beats tick
    while (!tick_due(0)) idle(1);
    wr(8'h08, 32'h77, 2'd2);
    rd_chk(8'h08, 32'h77, "R10 write wins");

    // R9 one-shot on channel 1
    wr(8'h10, 0, 2'd2);
    wr(8'h14, 3, 2'd2);
    wr(8'h00, 32'h3, 2'd0);
    idle(40);
    rd_chk(8'h18, 32'h120, "R9 first underflow");
    wr(8'h18, 32'h20, 2'd1);
    idle(60);
    rd_chk(8'h18, 32'h20, "R9 no repeat");
    check(irq[1] == 0, "R9 irq1 quiet", 32'(irq[1]), 0);
    wr(8'h14, 1, 2'd2);
    idle(20);
    rd_chk(8'h18, 32'h120, "R9 rearmed");

    // R5 reserved select and divide-by-16 on channel 2, R4 halt
    wr(8'h20, 32'h2, 2'd2);
    wr(8'h24, 32'h27, 2'd1);
    wr(8'h20, 100, 2'd2);
    wr(8'h00, 32'h7, 2'd0);
    idle(40);
    rd_chk(8'h20, 90, "R5 reserved select");
    wr(8'h00, 32'h3, 2'd0);
    rd_get(8'h20, v1);
    idle(50);
    rd_get(8'h20, v2);
    check(v1 == v2, "R4 halt holds", v2, v1);
    wr(8'h24, 32'h21, 2'd1);
    wr(8'h20, 100, 2'd2);
    wr(8'h00, 32'h7, 2'd0);
    idle(32);
    rd_chk(8'h20, 98, "R5 divide 16");
    rd_chk(8'h00, 32'h7, "R4 run readback");

    idle(4);
    done = 1;
    void'(fin());
    $finish;
  end
endmodule